// File: doc/BRIEF.md
# Three-Channel Command Mailbox Register Bank

This block is a memory-mapped mailbox that connects a host processor to a power-management microcontroller. It has three independent channels, each with a low and a high 32-bit data word, a combined command/status word and a flag word. The host fills the data words and then writes a command word to a shared issue location. Bits 7:6 of the 8-bit command code pick the channel. The block strips those two bits, latches the command and its two 8-bit parameters into the addressed channel, sets that channel's run flag, and sends a one-cycle request strobe to the controller side.

The controller side reads the latched command, the parameters and the input data from its own port. It finishes the command with a done pulse that carries an error code and the result data. The done pulse clears the run flag, writes the result into the data words and the error code into the low byte of the command/status word, and sets an interrupt-pending flag. A host that does not use the interrupt can poll the run flag instead. Each channel also has a cycle counter that flags a timeout when the run flag stays set for too long. A command sent to the reserved channel type never reaches the controller and finishes at once with the invalid-command error code.

The host interface uses word addresses (4 bits). Channel c occupies words 4c to 4c+3: low data, high data, command/status, flags. Word 12 is the issue location and word 13 is the reserved-type status.

Top module: `cmd_mailbox_bank`

## Requirements
- R1: Writing word 12 with bit 31 set and bits 7:6 equal to 0, 1 or 2 selects channel 0, 1 or 2. That channel becomes busy. Its command/status word then reads bit 31 = 1, bits 23:16 = second parameter (write bits 23:16), bits 15:8 = first parameter (write bits 15:8), bits 5:0 = command code with the type bits removed, and all other bits 0.
- R2: The issue edge is followed by exactly one cycle of `ctl_req` high for the selected channel. During that cycle the controller port shows the latched code, both parameters and the channel's data words.
- R3: A `ctl_done` pulse on a busy channel clears bit 31. It puts the error code (0 success, 1 invalid command, 2 invalid parameter, 3 timeout, 4 locked, 5 bad regulator id, 6 regulator fault) in bits 7:0 and keeps the parameters. It loads the low result word, sets flag bit 0 (interrupt pending) and raises `host_irq`.
- R4: Channel 0 has no high data word. Its word 1 always reads 0, and neither host writes nor results change it. Channels 1 and 2 pass the high word in both directions.
- R5: While a channel is busy, host writes to either of its data words and issues aimed at it are dropped. The data and the latched command stay unchanged, and flag bit 1 (overrun) is set.
- R6: Writing 1 to a flag bit 0 or 1 clears it. `host_irq` is low when no pending bit is set anywhere.
- R7: Flag bit 2 (timeout) is set once a channel has been busy for TIMEOUT_CYCLES cycles without completing. It is not set if completion comes earlier, and the next accepted issue clears it. The timeout does not end the command.
- R8: An issue with type bits 3 sends nothing to the controller. Word 13 then reads bit 0 = 1 (pending, write-1-to-clear) and bits 15:8 = 1, and `host_irq` rises.
- R9: After reset every register reads 0, nothing is busy and `host_irq` is low.
- R10: A write to word 12 with bit 31 clear has no effect.
- R11: A `ctl_done` on an idle channel has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| host_irq | output | 1 | Completion interrupt toward the host |
| ctl_req | output | 3 | One-cycle new-command strobe per channel |
| ctl_busy | output | 3 | Run flag per channel |
| ctl_code | output | 3x6 | Latched command code per channel |
| ctl_p1 | output | 3x8 | First parameter per channel |
| ctl_p2 | output | 3x8 | Second parameter per channel |
| ctl_din_lo | output | 3x32 | Low input data word per channel |
| ctl_din_hi | output | 3x32 | High input data word per channel |
| ctl_done | input | 3 | Completion pulse per channel |
| ctl_err | input | 3x8 | Error code returned with completion |
| ctl_dout_lo | input | 3x32 | Low result word |
| ctl_dout_hi | input | 3x32 | High result word |

## Verification
A corrupted run flag appears on the cycle after the issue edge. It shows as a missing or extra `ctl_req` strobe, or as bit 31 of the command/status word disagreeing with `ctl_busy`. A bad completion path shows in the next host read of the data and command/status words, and in `host_irq` one cycle after the done pulse. An overrun guard that fails to block a write changes the data word the controller sees on the very next cycle. A wrong timeout count moves flag bit 2 by at least one cycle from the TIMEOUT_CYCLES boundary, and the bench samples on both sides of that boundary.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NCH      = 3;
    localparam int DW       = 32;
    localparam int WAW      = 4;
    localparam int CODE_W   = 6;
    localparam int PARAM_W  = 8;
    localparam int ERR_W    = 8;

    localparam logic [WAW-1:0] ISSUE_WORD = WAW'(12);
    localparam logic [WAW-1:0] RSV_WORD   = WAW'(13);

    localparam int SLOT_LO = 0;
    localparam int SLOT_HI = 1;
    localparam int SLOT_IF = 2;
    localparam int SLOT_FL = 3;

    localparam int FL_IRQ = 0;
    localparam int FL_OVR = 1;
    localparam int FL_TMO = 2;

    typedef enum logic [1:0] {
        TY_FW  = 2'd0,
        TY_GFX = 2'd1,
        TY_IMG = 2'd2,
        TY_RSV = 2'd3
    } chan_type_e;

    typedef enum logic [ERR_W-1:0] {
        E_OK        = 8'd0,
        E_BAD_CMD   = 8'd1,
        E_BAD_PARAM = 8'd2,
        E_TIMEOUT   = 8'd3,
        E_LOCKED    = 8'd4,
        E_BAD_REG   = 8'd5,
        E_REG_FAULT = 8'd6
    } err_e;

    typedef struct packed {
        logic [PARAM_W-1:0] p2;
        logic [PARAM_W-1:0] p1;
        logic [CODE_W-1:0]  code;
    } cmd_s;

    typedef struct packed {
        logic       run;
        chan_type_e ctype;
        cmd_s       cmd;
    } issue_s;

    function automatic issue_s decode_issue(input logic [DW-1:0] w);
        issue_s r;
        r.run      = w[31];
        r.ctype    = chan_type_e'(w[7:6]);
        r.cmd.p2   = w[23:16];
        r.cmd.p1   = w[15:8];
        r.cmd.code = w[5:0];
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_iface(input logic busy, input cmd_s c,
                                                 input logic [ERR_W-1:0] low);
        return {busy, 7'b0, c.p2, c.p1, low};
    endfunction

    function automatic logic [WAW-1:0] slot_word(input int ch, input int slot);
        return WAW'(ch * 4 + slot);
    endfunction

endpackage

// File: rtl/mbx_tmo_timer.sv
module mbx_tmo_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic running,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (running && !expired) begin
            if (cnt == LAST) expired <= 1'b1;
            else             cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter bit HAS_HI       = 1'b1,
    parameter int TMO_CYCLES   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_fl,
    input  logic [DW-1:0]     wdata,
    input  logic              issue,
    input  cmd_s              issue_cmd,
    input  logic              done,
    input  logic [ERR_W-1:0]  done_err,
    input  logic [DW-1:0]     done_lo,
    input  logic [DW-1:0]     done_hi,
    output logic [DW-1:0]     lo_q,
    output logic [DW-1:0]     hi_q,
    output logic [DW-1:0]     iface_q,
    output logic [DW-1:0]     flags_q,
    output logic              busy,
    output logic              req,
    output cmd_s              cmd_q,
    output logic              irq_pend
);
    logic [ERR_W-1:0] low_byte;
    logic             ovr;
    logic             tmo;
    logic             accept;

    assign accept = issue && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            req      <= 1'b0;
            cmd_q    <= '0;
            low_byte <= '0;
            lo_q     <= '0;
            irq_pend <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            req <= accept;
            if (wr_fl) begin
                if (wdata[FL_IRQ]) irq_pend <= 1'b0;
                if (wdata[FL_OVR]) ovr      <= 1'b0;
            end
            if (busy) begin
                if (wr_lo || wr_hi || issue) ovr <= 1'b1;
                if (done) begin
                    busy     <= 1'b0;
                    low_byte <= done_err;
                    lo_q     <= done_lo;
                    irq_pend <= 1'b1;
                end
            end else begin
                if (wr_lo) lo_q <= wdata;
                if (issue) begin
                    busy     <= 1'b1;
                    cmd_q    <= issue_cmd;
                    low_byte <= {{(ERR_W-CODE_W){1'b0}}, issue_cmd.code};
                end
            end
        end
    end

    generate
        if (HAS_HI) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)                 hi_q <= '0;
                else if (busy && done)   hi_q <= done_hi;
                else if (!busy && wr_hi) hi_q <= wdata;
            end
        end else begin : g_no_hi
            logic unused_hi;
            assign unused_hi = ^{wr_hi, done_hi};
            assign hi_q      = '0;
        end
    endgenerate

    mbx_tmo_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .running (busy && !done),
        .expired (tmo)
    );

    assign iface_q = pack_iface(busy, cmd_q, low_byte);
    assign flags_q = {{(DW-3){1'b0}}, tmo, ovr, irq_pend};
endmodule

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
(
    input  logic                     wr_en,
    input  logic [WAW-1:0]           addr,
    input  logic [DW-1:0]            wdata,
    input  logic [NCH-1:0][DW-1:0]   rd_lo,
    input  logic [NCH-1:0][DW-1:0]   rd_hi,
    input  logic [NCH-1:0][DW-1:0]   rd_if,
    input  logic [NCH-1:0][DW-1:0]   rd_fl,
    input  logic [DW-1:0]            rd_rsv,
    output logic [NCH-1:0]           wr_lo,
    output logic [NCH-1:0]           wr_hi,
    output logic [NCH-1:0]           wr_fl,
    output logic [NCH-1:0]           iss_ch,
    output logic                     iss_rsv,
    output logic                     wr_rsv,
    output cmd_s                     iss_cmd,
    output logic [DW-1:0]            rdata
);
    issue_s iss;
    logic   iss_go;

    assign iss     = decode_issue(wdata);
    assign iss_cmd = iss.cmd;
    assign iss_go  = wr_en && (addr == ISSUE_WORD) && iss.run;
    assign iss_rsv = iss_go && (iss.ctype == TY_RSV);
    assign wr_rsv  = wr_en && (addr == RSV_WORD);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign wr_lo[c]  = wr_en && (addr == slot_word(c, SLOT_LO));
        assign wr_hi[c]  = wr_en && (addr == slot_word(c, SLOT_HI));
        assign wr_fl[c]  = wr_en && (addr == slot_word(c, SLOT_FL));
        assign iss_ch[c] = iss_go && (iss.ctype == chan_type_e'(c));
    end

    always_comb begin
        rdata = '0;
        if (addr == RSV_WORD) begin
            rdata = rd_rsv;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == slot_word(c, SLOT_LO)) rdata = rd_lo[c];
                if (addr == slot_word(c, SLOT_HI)) rdata = rd_hi[c];
                if (addr == slot_word(c, SLOT_IF)) rdata = rd_if[c];
                if (addr == slot_word(c, SLOT_FL)) rdata = rd_fl[c];
            end
        end
    end
endmodule

// File: rtl/cmd_mailbox_bank.sv
module cmd_mailbox_bank
    import mbx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 125_000_000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          host_wr,
    input  logic [WAW-1:0]                host_addr,
    input  logic [DW-1:0]                 host_wdata,
    output logic [DW-1:0]                 host_rdata,
    output logic                          host_irq,
    output logic [NCH-1:0]                ctl_req,
    output logic [NCH-1:0]                ctl_busy,
    output logic [NCH-1:0][CODE_W-1:0]    ctl_code,
    output logic [NCH-1:0][PARAM_W-1:0]   ctl_p1,
    output logic [NCH-1:0][PARAM_W-1:0]   ctl_p2,
    output logic [NCH-1:0][DW-1:0]        ctl_din_lo,
    output logic [NCH-1:0][DW-1:0]        ctl_din_hi,
    input  logic [NCH-1:0]                ctl_done,
    input  logic [NCH-1:0][ERR_W-1:0]     ctl_err,
    input  logic [NCH-1:0][DW-1:0]        ctl_dout_lo,
    input  logic [NCH-1:0][DW-1:0]        ctl_dout_hi
);
    logic [NCH-1:0][DW-1:0] rd_if, rd_fl;
    logic [NCH-1:0]         wr_lo, wr_hi, wr_fl, iss_ch, irq_pend;
    logic                   iss_rsv, wr_rsv;
    cmd_s                   iss_cmd;
    cmd_s [NCH-1:0]         cmd_q;
    logic                   rsv_pend;
    logic [ERR_W-1:0]       rsv_err;
    logic [DW-1:0]          rd_rsv;

    mbx_host_decode u_dec (
        .wr_en   (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .rd_lo   (ctl_din_lo),
        .rd_hi   (ctl_din_hi),
        .rd_if   (rd_if),
        .rd_fl   (rd_fl),
        .rd_rsv  (rd_rsv),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_fl   (wr_fl),
        .iss_ch  (iss_ch),
        .iss_rsv (iss_rsv),
        .wr_rsv  (wr_rsv),
        .iss_cmd (iss_cmd),
        .rdata   (host_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        mbx_channel #(
            .HAS_HI     (c != int'(TY_FW)),
            .TMO_CYCLES (TIMEOUT_CYCLES)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_lo     (wr_lo[c]),
            .wr_hi     (wr_hi[c]),
            .wr_fl     (wr_fl[c]),
            .wdata     (host_wdata),
            .issue     (iss_ch[c]),
            .issue_cmd (iss_cmd),
            .done      (ctl_done[c]),
            .done_err  (ctl_err[c]),
            .done_lo   (ctl_dout_lo[c]),
            .done_hi   (ctl_dout_hi[c]),
            .lo_q      (ctl_din_lo[c]),
            .hi_q      (ctl_din_hi[c]),
            .iface_q   (rd_if[c]),
            .flags_q   (rd_fl[c]),
            .busy      (ctl_busy[c]),
            .req       (ctl_req[c]),
            .cmd_q     (cmd_q[c]),
            .irq_pend  (irq_pend[c])
        );
        assign ctl_code[c] = cmd_q[c].code;
        assign ctl_p1[c]   = cmd_q[c].p1;
        assign ctl_p2[c]   = cmd_q[c].p2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_pend <= 1'b0;
            rsv_err  <= '0;
        end else begin
            if (wr_rsv && host_wdata[0]) rsv_pend <= 1'b0;
            if (iss_rsv) begin
                rsv_pend <= 1'b1;
                rsv_err  <= E_BAD_CMD;
            end
        end
    end

    assign rd_rsv   = {16'b0, rsv_err, 7'b0, rsv_pend};
    assign host_irq = (|irq_pend) | rsv_pend;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        host_wr,
    input logic [WAW-1:0]              host_addr,
    input logic [DW-1:0]               host_wdata,
    input logic                        host_irq,
    input logic [NCH-1:0]              ctl_req,
    input logic [NCH-1:0]              ctl_busy,
    input logic [NCH-1:0][CODE_W-1:0]  ctl_code,
    input logic [NCH-1:0][PARAM_W-1:0] ctl_p1,
    input logic [NCH-1:0][DW-1:0]      ctl_din_lo,
    input logic [NCH-1:0]              ctl_done,
    input logic [NCH-1:0][DW-1:0]      ctl_dout_lo
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        assert_req_single_R2: assert property (@(posedge clk) disable iff (rst)
            ctl_req[c] |=> !ctl_req[c]);
        assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
            ctl_req[c] |-> ctl_busy[c]);
        assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
            (ctl_busy[c] && !ctl_done[c]) |=>
                ($stable(ctl_code[c]) && $stable(ctl_p1[c]) && $stable(ctl_din_lo[c])));
        assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
            (ctl_busy[c] && ctl_done[c]) |=>
                (!ctl_busy[c] && host_irq && ctl_din_lo[c] == $past(ctl_dout_lo[c])));
        assert_idle_done_R11: assert property (@(posedge clk) disable iff (rst)
            (!ctl_busy[c] && ctl_done[c] && !(host_wr && host_addr == slot_word(c, SLOT_LO)))
                |=> $stable(ctl_din_lo[c]));
    end

    assert_rsv_not_forwarded_R8: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ISSUE_WORD && host_wdata[31] && host_wdata[7:6] == 2'b11)
            |=> (ctl_req == '0 && host_irq));

    assert_reset_state_R9: assert property (@(posedge clk)
        $past(rst) |-> (ctl_busy == '0 && ctl_req == '0 && !host_irq));
endmodule

bind cmd_mailbox_bank mbx_checker u_chk (.*);

// File: tb/cmd_mailbox_bank_test.sv
module cmd_mailbox_bank_test;
    import mbx_pkg::*;

    localparam int TMO = 20;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic                          host_wr = 1'b0;
    logic [WAW-1:0]                host_addr = '0;
    logic [DW-1:0]                 host_wdata = '0;
    logic [DW-1:0]                 host_rdata;
    logic                          host_irq;
    logic [NCH-1:0]                ctl_req, ctl_busy;
    logic [NCH-1:0][CODE_W-1:0]    ctl_code;
    logic [NCH-1:0][PARAM_W-1:0]   ctl_p1, ctl_p2;
    logic [NCH-1:0][DW-1:0]        ctl_din_lo, ctl_din_hi;
    logic [NCH-1:0]                ctl_done = '0;
    logic [NCH-1:0][ERR_W-1:0]     ctl_err = '0;
    logic [NCH-1:0][DW-1:0]        ctl_dout_lo = '0;
    logic [NCH-1:0][DW-1:0]        ctl_dout_hi = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmd_mailbox_bank #(.TIMEOUT_CYCLES(TMO)) uut (.*);

    typedef struct packed {
        logic [1:0]  ch;
        logic [5:0]  code;
        logic [7:0]  p1;
        logic [7:0]  p2;
        logic [31:0] din_lo;
        logic [31:0] din_hi;
        logic [7:0]  err;
        logic [31:0] dout_lo;
        logic [31:0] dout_hi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'h05, 8'h11, 8'h22, 32'hA5A5_0001, 32'hDEAD_0000, 8'd0, 32'h1234_5678, 32'hFFFF_0001},
        '{2'd1, 6'h17, 8'h3C, 8'h00, 32'h0000_00FF, 32'h8000_0000, 8'd0, 32'hCAFE_0001, 32'hBEEF_0002},
        '{2'd2, 6'h03, 8'hFF, 8'hFF, 32'hFFFF_FFFF, 32'h0000_0000, 8'd2, 32'h0000_0000, 32'h0000_1111},
        '{2'd0, 6'h1B, 8'h00, 8'h07, 32'h0000_0001, 32'h0000_0002, 8'd6, 32'h8000_0000, 32'h0000_0005},
        '{2'd1, 6'h3F, 8'h80, 8'h01, 32'h5555_AAAA, 32'h0F0F_F0F0, 8'd4, 32'h0000_0042, 32'h7777_0000},
        '{2'd2, 6'h00, 8'h01, 8'h80, 32'h0102_0304, 32'h0506_0708, 8'd3, 32'h1111_2222, 32'h3333_4444}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic complete(input int ch, input logic [7:0] e, input logic [31:0] lo,
                            input logic [31:0] hi);
        @(negedge clk);
        ctl_done[ch] = 1'b1; ctl_err[ch] = e; ctl_dout_lo[ch] = lo; ctl_dout_hi[ch] = hi;
        @(negedge clk);
        ctl_done = '0;
    endtask

    function automatic logic [31:0] issue_word(input logic [1:0] ch, input logic [5:0] code,
                                               input logic [7:0] p1, input logic [7:0] p2);
        return {1'b1, 7'b0, p2, p1, ch, code};
    endfunction

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        hread(4'd2, d);  check("R9 iface ch0", d, 32'h0);
        hread(4'd7, d);  check("R9 flags ch1", d, 32'h0);
        check("R9 irq", {31'b0, host_irq}, 32'h0);
        check("R9 busy", {29'b0, ctl_busy}, 32'h0);

        // vector table: R1 R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            logic [3:0] b = {v.ch, 2'b00};
            logic [31:0] hi_in_exp = (v.ch == 2'd0) ? 32'h0 : v.din_hi;
            logic [31:0] hi_out_exp = (v.ch == 2'd0) ? 32'h0 : v.dout_hi;
            hwrite(b, v.din_lo);
            hwrite(b + 4'd1, v.din_hi);
            hwrite(4'd12, issue_word(v.ch, v.code, v.p1, v.p2));
            check("R2 req strobe", {29'b0, ctl_req}, 32'(1 << v.ch));
            check("R2 code", {26'b0, ctl_code[v.ch]}, {26'b0, v.code});
            check("R2 params", {16'b0, ctl_p2[v.ch], ctl_p1[v.ch]}, {16'b0, v.p2, v.p1});
            check("R2 din lo", ctl_din_lo[v.ch], v.din_lo);
            check("R4 din hi", ctl_din_hi[v.ch], hi_in_exp);
            hread(b + 4'd2, d);
            check("R1 iface busy", d, {1'b1, 7'b0, v.p2, v.p1, 2'b00, v.code});
            check("R2 req single", {29'b0, ctl_req}, 32'h0);
            complete(int'(v.ch), v.err, v.dout_lo, v.dout_hi);
            check("R3 irq", {31'b0, host_irq}, 32'h1);
            hread(b + 4'd2, d);
            check("R3 iface done", d, {8'b0, v.p2, v.p1, v.err});
            hread(b, d);     check("R3 lo out", d, v.dout_lo);
            hread(b + 4'd1, d); check("R4 hi out", d, hi_out_exp);
            hread(b + 4'd3, d); check("R3 flag pend", d, 32'h1);
            hwrite(b + 4'd3, 32'h1);
            hread(b + 4'd3, d); check("R6 flag cleared", d, 32'h0);
            check("R6 irq low", {31'b0, host_irq}, 32'h0);
        end

        // R10: issue without run bit
        hwrite(4'd12, 32'h0000_0141);
        check("R10 no req", {29'b0, ctl_req}, 32'h0);
        check("R10 not busy", {29'b0, ctl_busy}, 32'h0);

        // R11: done while idle
        hwrite(4'd4, 32'h0000_ABCD);
        complete(1, 8'd5, 32'h9999_9999, 32'h8888_8888);
        hread(4'd4, d); check("R11 lo kept", d, 32'h0000_ABCD);
        hread(4'd7, d); check("R11 no pend", d, 32'h0);

        // R5: overrun while busy, R7: timeout
        hwrite(4'd12, issue_word(2'd1, 6'h0A, 8'h01, 8'h02));
        repeat (TMO - 2) @(negedge clk);
        hread(4'd7, d); check("R7 before limit", d, 32'h0);
        hread(4'd7, d); check("R7 at limit", d, 32'h4);
        hwrite(4'd4, 32'h1111_1111);
        hwrite(4'd12, issue_word(2'd1, 6'h2C, 8'hEE, 8'hDD));
        hread(4'd4, d); check("R5 lo blocked", d, 32'h0000_ABCD);
        hread(4'd6, d); check("R5 cmd kept", d, {1'b1, 7'b0, 8'h02, 8'h01, 8'h0A});
        hread(4'd7, d); check("R5 overrun", d, 32'h6);
        hwrite(4'd7, 32'h2);
        hread(4'd7, d); check("R6 overrun clear", d, 32'h4);
        complete(1, 8'd0, 32'h0, 32'h0);
        hwrite(4'd7, 32'h1);
        hwrite(4'd12, issue_word(2'd1, 6'h01, 8'h00, 8'h00));
        hread(4'd7, d); check("R7 cleared on issue", d, 32'h0);
        complete(1, 8'd0, 32'h0, 32'h0);
        hwrite(4'd7, 32'h1);

        // R4: channel 0 high word write ignored
        hwrite(4'd1, 32'hFFFF_FFFF);
        hread(4'd1, d); check("R4 ch0 hi zero", d, 32'h0);

        // R8: reserved type
        hwrite(4'd12, issue_word(2'd3, 6'h04, 8'h00, 8'h00));
        check("R8 no req", {29'b0, ctl_req}, 32'h0);
        check("R8 irq", {31'b0, host_irq}, 32'h1);
        hread(4'd13, d); check("R8 rsv status", d, 32'h0000_0101);
        hwrite(4'd13, 32'h1);
        hread(4'd13, d); check("R8 rsv clear", d, 32'h0000_0100);
        check("R6 irq low end", {31'b0, host_irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule